// File: doc/BRIEF.md
# RF Interface Modem Status and Control Register

An 8-bit register for a cellular RF interface chip, reached over a plain microcontroller bus made of an address, a read strobe, a write strobe and a byte of write data. Reading it returns live status:

- the synthesizer-unlock pin level;
- the transmitter-on indicator pin level;
- a synthesizer-programming-ready flag;
- a conversion-ready flag.

Writing it sets three control fields:

- the master clock output enable;
- the 2-bit full-scale range shared by every auxiliary DAC;
- a software PA enable.

The block also drives the external PA enable and a permit for the transmit I/Q outputs. It combines the software PA bit, a transmit-request input and a digital-mode input with the synchronized unlock level. In digital mode, an unlocked synthesizer blocks transmission whatever software has written. The conversion-ready flag is set by a completion pulse from the A/D side. It is cleared as a side effect of reading either of two result addresses that belong to neighbouring registers.

The A/D converters, the DACs, the synthesizer serial engine and the clock generator are outside the block. They appear only as handshake inputs.

Top module: `rfif_status_ctrl`

## Requirements
- R1: After reset, a read of the status address returns 8'h38 while both status pins are low and the synthesizer-idle input is high. In that value, bit 5 (synth ready) = 1, bit 4 (clock enable) = 1, bit 3 (conversion ready) = 1, bits 2:1 (DAC range) = 00 and bit 0 (PA software enable) = 0.
- R2: Bit 7 returns the synthesizer-unlock pin and bit 6 returns the transmitter-on pin. Each goes through a two-flop synchronizer, so a pin level is readable after two rising edges.
- R3: Bit 5 returns the synthesizer-idle input (1 = ready, 0 = busy) one rising edge after it changes.
- R4: A write to the status address loads bits 4, 2:1 and 0 from the write data. The values written to bits 7, 6, 5 and 3 have no effect.
- R5: While bit 4 is 1, `mclk_out` equals `mclk_in`. While bit 4 is 0, `mclk_out` is held at 0.
- R6: `aux_range` always equals bits 2:1.
- R7: A one-cycle `conv_done` pulse sets bit 3 at the next rising edge.
- R8: A read of the signal-strength result address or of the battery result address clears bit 3 at that edge. A read of the status address leaves bit 3 unchanged.
- R9: If `conv_done` and a result-address read fall in the same cycle, bit 3 ends up set.
- R10: `pa_enable` is 1 exactly when bit 0 is 1, `tx_request` is 1, and digital mode is not combined with a synchronized unlock level of 1.
- R11: `txiq_enable` is 0 exactly when `digital_mode` is 1 and the synchronized unlock level is 1.
- R12: `bus_rdata` is 8'h00 in every cycle that is not a read of the status address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe |
| synth_unlock_pin | input | 1 | Asynchronous synthesizer out-of-lock level |
| tx_on_pin | input | 1 | Asynchronous transmitter-on indicator level |
| synth_idle | input | 1 | Synthesizer programming interface ready |
| conv_done | input | 1 | Pulse marking the end of a signal-strength or battery conversion |
| digital_mode | input | 1 | Digital modulation mode active |
| tx_request | input | 1 | Transmit burst requested |
| mclk_in | input | 1 | Master clock from the clock generator |
| mclk_out | output | 1 | Gated master clock output |
| aux_range | output | 2 | Full-scale range select for all auxiliary DACs |
| pa_enable | output | 1 | External power amplifier enable |
| txiq_enable | output | 1 | Permit for the transmit I/Q outputs |

## Verification
The PA interlock is tried with all sixteen combinations of software bit, transmit request, digital mode and unlock level. The combinations show that each of the three terms alone can hold the PA off, and that unlock blocks only in digital mode. The conversion flag is cleared once through each result address and once through a status read that must not clear it. A completion pulse coinciding with a clear is applied both with the flag set and with it cleared, which separates "set wins" from "flag unchanged". Writes of all-ones and all-zeros patterns show which bit positions can be written.

// File: rtl/rfif_sc_pkg.sv
`timescale 1ns/1ps
package rfif_sc_pkg;
  localparam int STAT_W     = 8;
  localparam int B_UNLOCK   = 7;
  localparam int B_TXON     = 6;
  localparam int B_SYRDY    = 5;
  localparam int B_CLKEN    = 4;
  localparam int B_CVRDY    = 3;
  localparam int B_RANGE_HI = 2;
  localparam int B_RANGE_LO = 1;
  localparam int B_PASW     = 0;

  typedef struct packed {
    logic       clk_en;
    logic [1:0] range;
    logic       pa_sw;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{clk_en: 1'b1, range: 2'b00, pa_sw: 1'b0};

  function automatic logic iq_permit(input logic dig, input logic unlock);
    return !(dig && unlock);
  endfunction

  function automatic logic pa_permit(input logic sw, input logic txreq,
                                     input logic dig, input logic unlock);
    return sw && txreq && iq_permit(dig, unlock);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
      input logic unlock, input logic txon, input logic syrdy,
      input logic cvrdy, input ctrl_t c);
    logic [STAT_W-1:0] s;
    s             = '0;
    s[B_UNLOCK]   = unlock;
    s[B_TXON]     = txon;
    s[B_SYRDY]    = syrdy;
    s[B_CLKEN]    = c.clk_en;
    s[B_CVRDY]    = cvrdy;
    s[B_RANGE_HI] = c.range[1];
    s[B_RANGE_LO] = c.range[0];
    s[B_PASW]     = c.pa_sw;
    return s;
  endfunction
endpackage

// File: rtl/rfif_sync.sv
`timescale 1ns/1ps
module rfif_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];
  logic         live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg[0] <= RST_VAL;
      live_q <= 1'b0;
    end else begin
      stg[0] <= din;
      live_q <= 1'b1;
    end
  end

  // R2
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    stg[0] == $past(din));

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
    // R2
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      stg[i] == $past(stg[i-1]));
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/rfif_ctrl_regs.sv
`timescale 1ns/1ps
module rfif_ctrl_regs
  import rfif_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [STAT_W-1:0] wdata,
  input  logic              result_rd,
  input  logic              conv_done,
  output ctrl_t             ctrl,
  output logic              cv_flag
);
  ctrl_t ctrl_q;
  logic  cv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_hit) begin
      ctrl_q.clk_en <= wdata[B_CLKEN];
      ctrl_q.range  <= {wdata[B_RANGE_HI], wdata[B_RANGE_LO]};
      ctrl_q.pa_sw  <= wdata[B_PASW];
    end
  end

  // a completion in the same cycle as a clearing read wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cv_q <= 1'b1;
    else if (conv_done) cv_q <= 1'b1;
    else if (result_rd) cv_q <= 1'b0;
  end

  assign ctrl    = ctrl_q;
  assign cv_flag = cv_q;

  // R4
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ctrl.pa_sw == $past(wdata[B_PASW])) && (ctrl.clk_en == $past(wdata[B_CLKEN])));
  // R4
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl));
  // R7
  cv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> cv_flag);
  // R8
  cv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_rd && !conv_done) |=> !cv_flag);
  // R9
  cv_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_flag) |-> $past(conv_done));
endmodule

// File: rtl/rfif_pa_gate.sv
`timescale 1ns/1ps
module rfif_pa_gate
  import rfif_sc_pkg::*;
(
  input  logic pa_sw,
  input  logic tx_request,
  input  logic digital_mode,
  input  logic unlock_s,
  input  logic clk_en,
  input  logic mclk_in,
  output logic pa_enable,
  output logic txiq_enable,
  output logic mclk_out
);
  always_comb begin
    txiq_enable = iq_permit(digital_mode, unlock_s);
    pa_enable   = pa_permit(pa_sw, tx_request, digital_mode, unlock_s);
    mclk_out    = mclk_in & clk_en;
  end
endmodule

// File: rtl/rfif_status_ctrl.sv
`timescale 1ns/1ps
module rfif_status_ctrl
  import rfif_sc_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] RSSI_ADDR = 4'h8,
  parameter logic [ADDR_W-1:0] BATT_ADDR = 4'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  input  logic              synth_unlock_pin,
  input  logic              tx_on_pin,
  input  logic              synth_idle,
  input  logic              conv_done,
  input  logic              digital_mode,
  input  logic              tx_request,
  input  logic              mclk_in,
  output logic              mclk_out,
  output logic [1:0]        aux_range,
  output logic              pa_enable,
  output logic              txiq_enable
);
  localparam int PIN_W = 2;

  logic       stat_wr_hit, stat_rd_hit, result_rd_hit;
  logic [PIN_W-1:0] pins_s;
  logic       unlock_s, txon_s, syrdy_q;
  ctrl_t      ctrl;
  logic       cv_flag;

  assign stat_wr_hit   = bus_wr && (bus_addr == STAT_ADDR);
  assign stat_rd_hit   = bus_rd && (bus_addr == STAT_ADDR);
  assign result_rd_hit = bus_rd && ((bus_addr == RSSI_ADDR) || (bus_addr == BATT_ADDR));

  rfif_sync #(.W(PIN_W), .STAGES(2), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .din({synth_unlock_pin, tx_on_pin}), .dout(pins_s)
  );
  assign unlock_s = pins_s[1];
  assign txon_s   = pins_s[0];

  rfif_sync #(.W(1), .STAGES(1), .RST_VAL(1'b1)) u_rdy_reg (
    .clk(clk), .rst_n(rst_n), .din(synth_idle), .dout(syrdy_q)
  );

  rfif_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(stat_wr_hit), .wdata(bus_wdata),
    .result_rd(result_rd_hit), .conv_done(conv_done),
    .ctrl(ctrl), .cv_flag(cv_flag)
  );

  rfif_pa_gate u_gate (
    .pa_sw(ctrl.pa_sw), .tx_request(tx_request), .digital_mode(digital_mode),
    .unlock_s(unlock_s), .clk_en(ctrl.clk_en), .mclk_in(mclk_in),
    .pa_enable(pa_enable), .txiq_enable(txiq_enable), .mclk_out(mclk_out)
  );

  assign aux_range = ctrl.range;
  assign bus_rdata = stat_rd_hit ? pack_status(unlock_s, txon_s, syrdy_q, cv_flag, ctrl)
                                 : '0;

  // R10
  pa_needs_iq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_enable |-> (txiq_enable && tx_request));
  // R11
  unlock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digital_mode && unlock_s) |-> (!pa_enable && !txiq_enable));
  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_hit |-> (bus_rdata == '0));
  // R5
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.clk_en |-> !mclk_out);
endmodule

// File: tb/tb_rfif_status_ctrl.sv
`timescale 1ns/1ps
module tb_rfif_status_ctrl;
  localparam logic [3:0] A_STAT = 4'h3;
  localparam logic [3:0] A_RSSI = 4'h8;
  localparam logic [3:0] A_BATT = 4'h9;
  localparam logic [3:0] A_OTHR = 4'h5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       synth_unlock_pin = 1'b0, tx_on_pin = 1'b0, synth_idle = 1'b1;
  logic       conv_done = 1'b0, digital_mode = 1'b0, tx_request = 1'b0, mclk_in = 1'b0;
  logic       mclk_out, pa_enable, txiq_enable;
  logic [1:0] aux_range;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rfif_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .synth_unlock_pin(synth_unlock_pin),
    .tx_on_pin(tx_on_pin), .synth_idle(synth_idle), .conv_done(conv_done),
    .digital_mode(digital_mode), .tx_request(tx_request), .mclk_in(mclk_in),
    .mclk_out(mclk_out), .aux_range(aux_range), .pa_enable(pa_enable),
    .txiq_enable(txiq_enable)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(A_STAT, d);
    chk("R1 reset status", d, 8'h38);
    chk("R6 reset range", {6'b0, aux_range}, 8'h00);
    chk("R10 reset pa", {7'b0, pa_enable}, 8'h00);
  endtask

  task automatic t_pins();
    logic [7:0] d;
    @(negedge clk); synth_unlock_pin = 1'b1; tx_on_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_read(A_STAT, d);
    chk("R2 unlock bit7", {6'b0, d[7:6]}, 8'h02);
    @(negedge clk); synth_unlock_pin = 1'b0; tx_on_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_read(A_STAT, d);
    chk("R2 txon bit6", {6'b0, d[7:6]}, 8'h01);
    @(negedge clk); tx_on_pin = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_synth_ready();
    logic [7:0] d;
    @(negedge clk); synth_idle = 1'b0;
    bus_read(A_STAT, d);
    chk("R3 busy", {7'b0, d[5]}, 8'h00);
    @(negedge clk); synth_idle = 1'b1;
    bus_read(A_STAT, d);
    chk("R3 ready", {7'b0, d[5]}, 8'h01);
  endtask

  task automatic t_write_mask();
    logic [7:0] d;
    bus_write(A_STAT, 8'hFF);
    bus_read(A_STAT, d);
    chk("R4 write ones", d, 8'h3F);
    chk("R6 range 11", {6'b0, aux_range}, 8'h03);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, d);
    chk("R4 write zeros keeps ro bits", d, 8'h28);
    bus_write(A_STAT, 8'h04);
    chk("R6 range 10", {6'b0, aux_range}, 8'h02);
    bus_write(A_OTHR, 8'h13);
    bus_read(A_STAT, d);
    chk("R4 other address ignored", d, 8'h2C);
  endtask

  task automatic t_mclk();
    bus_write(A_STAT, 8'h10);
    @(negedge clk); mclk_in = 1'b1; #1;
    chk("R5 enabled high", {7'b0, mclk_out}, 8'h01);
    mclk_in = 1'b0; #1;
    chk("R5 enabled low", {7'b0, mclk_out}, 8'h00);
    bus_write(A_STAT, 8'h00);
    @(negedge clk); mclk_in = 1'b1; #1;
    chk("R5 disabled", {7'b0, mclk_out}, 8'h00);
    mclk_in = 1'b0;
  endtask

  task automatic t_cvrdy();
    logic [7:0] d;
    bus_read(A_RSSI, d);
    chk("R12 result address rdata", d, 8'h00);
    bus_read(A_STAT, d);
    chk("R8 cleared by rssi read", {7'b0, d[3]}, 8'h00);
    pulse_done();
    bus_read(A_STAT, d);
    chk("R7 set by done", {7'b0, d[3]}, 8'h01);
    bus_read(A_STAT, d);
    chk("R8 status read keeps flag", {7'b0, d[3]}, 8'h01);
    bus_read(A_BATT, d);
    bus_read(A_STAT, d);
    chk("R8 cleared by battery read", {7'b0, d[3]}, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); bus_addr = A_BATT; bus_rd = 1'b1; conv_done = 1'b1;
    @(negedge clk); bus_rd = 1'b0; conv_done = 1'b0;
    bus_read(A_STAT, d);
    chk("R9 collision from clear", {7'b0, d[3]}, 8'h01);
    @(negedge clk); bus_addr = A_RSSI; bus_rd = 1'b1; conv_done = 1'b1;
    @(negedge clk); bus_rd = 1'b0; conv_done = 1'b0;
    bus_read(A_STAT, d);
    chk("R9 collision from set", {7'b0, d[3]}, 8'h01);
  endtask

  task automatic t_interlock();
    for (int v = 0; v < 16; v++) begin
      logic sw, rq, dg, ul, exp_pa, exp_iq;
      sw = v[3]; rq = v[2]; dg = v[1]; ul = v[0];
      bus_write(A_STAT, {7'b0001000, sw});
      @(negedge clk);
      tx_request = rq; digital_mode = dg; synth_unlock_pin = ul;
      @(negedge clk); @(negedge clk); #1;
      exp_iq = (dg && ul) ? 1'b0 : 1'b1;
      exp_pa = (sw && rq) ? exp_iq : 1'b0;
      chk($sformatf("R10 pa combo %0d", v), {7'b0, pa_enable}, {7'b0, exp_pa});
      chk($sformatf("R11 iq combo %0d", v), {7'b0, txiq_enable}, {7'b0, exp_iq});
    end
    @(negedge clk); tx_request = 1'b0; digital_mode = 1'b0; synth_unlock_pin = 1'b0;
  endtask

  task automatic t_idle_rdata();
    @(negedge clk); bus_addr = A_STAT; #1;
    chk("R12 no strobe", bus_rdata, 8'h00);
    bus_rd = 1'b1; bus_addr = A_OTHR; #1;
    chk("R12 other address", bus_rdata, 8'h00);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pins();
    t_synth_ready();
    t_write_mask();
    t_mclk();
    t_cvrdy();
    t_collision();
    t_interlock();
    t_idle_rdata();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule